// File: doc/BRIEF.md
# Asymmetric Dual-Port Block Memory

This block models one embedded memory tile shared by two ports that see the same storage at different widths. Port A is wide. It addresses whole words and writes them through per-byte lane enables. Port B is narrower. Its address counts in units of its own width, so it can reach every byte that port A writes. Both ports run on one clock and act in the same cycle without waiting on each other. A parameter fixes the tile in one of two modes. In simple mode, A only writes and B only reads. In true mode, both ports may read and write.

The contents come from a parameter vector and are loaded whenever reset is asserted. This lets the tile serve as a ROM or as a preset table. A read returns registered data one cycle after the request, and that data comes with a valid strobe. The tile cannot apply back-pressure, so there is no ready signal. A requester must take the data in the cycle its valid strobe is high. The data outputs keep their value until the next read on the same port. Port widths are byte-lane multiples: A carries `A_LANES` lanes and B carries `B_LANES` lanes. Both counts are powers of two, with `A_LANES >= 2` and `B_LANES` dividing `A_LANES`.

Top module: `asym_dp_ram`

## Requirements
- R1: While `rst` is high, both valid outputs are low, both data outputs are zero, and every lane is loaded from `INIT`. Lane n is `INIT[n*LANE_W +: LANE_W]`, and lane n is byte n%A_LANES of A word n/A_LANES.
- R2: A port B request with `b_en`=1 and `b_we`=0 raises `b_rvalid` on the next cycle. In that cycle `b_rdata` carries the addressed lanes, and `b_rvalid` is low in every other cycle.
- R3: Port B address equals the A word address followed by the lane-select bits. `b_rdata` lane k holds A lane (select*B_LANES + k), and lane 0 is the least significant byte on both ports.
- R4: A port A write updates exactly the lanes whose `a_be` bit is set. The other lanes of the word keep their value.
- R5: When one port reads a location in the same cycle that the other port writes it, the read returns the data from before the write.
- R6: In true mode, a byte written by both ports in the same cycle takes port A's value. Port B's other lanes in that cycle are still written.
- R7: In simple mode, `a_rvalid` stays low and `a_rdata` stays zero. A port B request with `b_we`=1 writes nothing and returns no data.
- R8: In true mode, a port A request with `a_we`=0 returns the addressed word on `a_rdata` one cycle later with `a_rvalid` high. A port B write stores the lanes that `b_be` enables.
- R9: A data output keeps its value in any cycle that follows a cycle with no read on that port.
- R10: A write on one port and a read on the other port, at different locations in the same cycle, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; reloads contents |
| a_en | input | 1 | Port A request |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_be | input | A_LANES | Port A lane write enables |
| a_addr | input | AW | Port A word address |
| a_wdata | input | A_LANES*LANE_W | Port A write data |
| a_rdata | output | A_LANES*LANE_W | Port A registered read data |
| a_rvalid | output | 1 | Port A read data valid |
| b_en | input | 1 | Port B request |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_be | input | B_LANES | Port B lane write enables |
| b_addr | input | BW | Port B narrow address |
| b_wdata | input | B_LANES*LANE_W | Port B write data |
| b_rdata | output | B_LANES*LANE_W | Port B registered read data |
| b_rvalid | output | 1 | Port B read data valid |

## Verification
The hardest case to reach is a same-cycle clash. It needs both ports on one word, with overlapping and non-overlapping lane masks, and it must happen while the memory already holds known, distinct byte values. The stimulus reaches it by building the port B address from the A word address plus a chosen lane. It then runs a long pseudo-random phase confined to a few words, so that read-first collisions and A-over-B priority keep recurring. A simple-mode copy of the tile is driven in parallel, so the same patterns also show that B writes are dropped there.

// File: rtl/amem_pkg.sv
package amem_pkg;
  typedef enum logic {
    MODE_SIMPLE = 1'b0,
    MODE_TRUE   = 1'b1
  } dp_mode_e;
endpackage

// File: rtl/amem_addr_map.sv
module amem_addr_map #(
  parameter int AW      = 8,
  parameter int LW      = 2,
  parameter int B_LANES = 1,
  localparam int BLW    = $clog2(B_LANES),
  localparam int SUBW   = LW - BLW,
  localparam int BW     = AW + SUBW
) (
  input  logic [BW-1:0] b_addr,
  output logic [AW-1:0] b_word,
  output logic [LW-1:0] b_lane0
);
  generate
    if (SUBW == 0) begin : g_same_width
      assign b_word  = b_addr;
      assign b_lane0 = '0;
    end else begin : g_narrow
      assign b_word  = b_addr[BW-1:SUBW];
      assign b_lane0 = LW'(b_addr[SUBW-1:0]) << BLW;
    end
  endgenerate
endmodule

// File: rtl/amem_wr_arb.sv
module amem_wr_arb #(
  parameter int AW      = 8,
  parameter int LW      = 2,
  parameter int A_LANES = 4,
  parameter int B_LANES = 1
) (
  input  logic               a_wr,
  input  logic [AW-1:0]      a_word,
  input  logic [A_LANES-1:0] a_be,
  input  logic               b_wr,
  input  logic [AW-1:0]      b_word,
  input  logic [LW-1:0]      b_lane0,
  input  logic [B_LANES-1:0] b_be,
  output logic [A_LANES-1:0] a_lane_we,
  output logic [B_LANES-1:0] b_lane_we
);
  logic same_word;
  assign same_word = a_wr && (a_word == b_word);
  assign a_lane_we = a_be & {A_LANES{a_wr}};

  generate
    for (genvar k = 0; k < B_LANES; k++) begin : g_lane
      logic [LW-1:0] lane;
      logic          a_hit;
      assign lane         = b_lane0 + LW'(k);
      assign a_hit        = same_word && a_be[lane];
      assign b_lane_we[k] = b_wr && b_be[k] && !a_hit;
    end
  endgenerate
endmodule

// File: rtl/amem_store.sv
module amem_store #(
  parameter int LANE_W  = 8,
  parameter int A_LANES = 4,
  parameter int B_LANES = 1,
  parameter int A_DEPTH = 256,
  localparam int NLANES = A_LANES * A_DEPTH,
  localparam int AW     = $clog2(A_DEPTH),
  localparam int LW     = $clog2(A_LANES),
  parameter logic [NLANES*LANE_W-1:0] INIT = '0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      a_rd,
  input  logic [AW-1:0]             a_word,
  input  logic [A_LANES-1:0]        a_lane_we,
  input  logic [A_LANES*LANE_W-1:0] a_wdata,
  output logic [A_LANES*LANE_W-1:0] a_q,
  input  logic                      b_rd,
  input  logic [AW-1:0]             b_word,
  input  logic [LW-1:0]             b_lane0,
  input  logic [B_LANES-1:0]        b_lane_we,
  input  logic [B_LANES*LANE_W-1:0] b_wdata,
  output logic [B_LANES*LANE_W-1:0] b_q
);
  logic [LANE_W-1:0] mem [NLANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NLANES; i++) mem[i] <= INIT[i*LANE_W +: LANE_W];
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (a_rd)
        for (int l = 0; l < A_LANES; l++)
          a_q[l*LANE_W +: LANE_W] <= mem[{a_word, LW'(l)}];
      if (b_rd)
        for (int k = 0; k < B_LANES; k++)
          b_q[k*LANE_W +: LANE_W] <= mem[{b_word, b_lane0 + LW'(k)}];
      for (int k = 0; k < B_LANES; k++)
        if (b_lane_we[k]) mem[{b_word, b_lane0 + LW'(k)}] <= b_wdata[k*LANE_W +: LANE_W];
      for (int l = 0; l < A_LANES; l++)
        if (a_lane_we[l]) mem[{a_word, LW'(l)}] <= a_wdata[l*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/asym_dp_ram.sv
module asym_dp_ram #(
  parameter int LANE_W  = 8,
  parameter int A_LANES = 4,
  parameter int B_LANES = 1,
  parameter int A_DEPTH = 256,
  parameter amem_pkg::dp_mode_e DP_MODE = amem_pkg::MODE_TRUE,
  localparam int NLANES = A_LANES * A_DEPTH,
  localparam int AW     = $clog2(A_DEPTH),
  localparam int LW     = $clog2(A_LANES),
  localparam int BW     = AW + LW - $clog2(B_LANES),
  localparam int A_W    = A_LANES * LANE_W,
  localparam int B_W    = B_LANES * LANE_W,
  parameter logic [NLANES*LANE_W-1:0] INIT = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               a_en,
  input  logic               a_we,
  input  logic [A_LANES-1:0] a_be,
  input  logic [AW-1:0]      a_addr,
  input  logic [A_W-1:0]     a_wdata,
  output logic [A_W-1:0]     a_rdata,
  output logic               a_rvalid,
  input  logic               b_en,
  input  logic               b_we,
  input  logic [B_LANES-1:0] b_be,
  input  logic [BW-1:0]      b_addr,
  input  logic [B_W-1:0]     b_wdata,
  output logic [B_W-1:0]     b_rdata,
  output logic               b_rvalid
);
  logic a_rd, a_wr, b_rd, b_wr;
  logic [AW-1:0]      b_word;
  logic [LW-1:0]      b_lane0;
  logic [A_LANES-1:0] a_lane_we;
  logic [B_LANES-1:0] b_lane_we;

  assign a_wr = a_en && a_we;
  assign b_rd = b_en && !b_we;

  generate
    if (DP_MODE == amem_pkg::MODE_TRUE) begin : g_true_dp
      assign a_rd = a_en && !a_we;
      assign b_wr = b_en && b_we;
    end else begin : g_simple_dp
      assign a_rd = 1'b0;
      assign b_wr = 1'b0;
    end
  endgenerate

  amem_addr_map #(.AW(AW), .LW(LW), .B_LANES(B_LANES)) u_map (
    .b_addr (b_addr),
    .b_word (b_word),
    .b_lane0(b_lane0)
  );

  amem_wr_arb #(.AW(AW), .LW(LW), .A_LANES(A_LANES), .B_LANES(B_LANES)) u_arb (
    .a_wr     (a_wr),
    .a_word   (a_addr),
    .a_be     (a_be),
    .b_wr     (b_wr),
    .b_word   (b_word),
    .b_lane0  (b_lane0),
    .b_be     (b_be),
    .a_lane_we(a_lane_we),
    .b_lane_we(b_lane_we)
  );

  amem_store #(
    .LANE_W(LANE_W), .A_LANES(A_LANES), .B_LANES(B_LANES),
    .A_DEPTH(A_DEPTH), .INIT(INIT)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .a_rd     (a_rd),
    .a_word   (a_addr),
    .a_lane_we(a_lane_we),
    .a_wdata  (a_wdata),
    .a_q      (a_rdata),
    .b_rd     (b_rd),
    .b_word   (b_word),
    .b_lane0  (b_lane0),
    .b_lane_we(b_lane_we),
    .b_wdata  (b_wdata),
    .b_q      (b_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rvalid <= 1'b0;
      b_rvalid <= 1'b0;
    end else begin
      a_rvalid <= a_rd;
      b_rvalid <= b_rd;
    end
  end
endmodule

// File: rtl/amem_checker.sv
module amem_checker #(
  parameter bit TDP = 1'b1,
  parameter int A_W = 32,
  parameter int B_W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           a_en,
  input logic           a_we,
  input logic           b_en,
  input logic           b_we,
  input logic [A_W-1:0] a_rdata,
  input logic           a_rvalid,
  input logic [B_W-1:0] b_rdata,
  input logic           b_rvalid
);
  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> !a_rvalid && !b_rvalid); // R1
  AST_B_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (b_en && !b_we) |=> b_rvalid); // R2
  AST_B_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !(b_en && !b_we) |=> !b_rvalid); // R2
  AST_SDP_A_SILENT: assert property (@(posedge clk) disable iff (rst)
    !TDP |-> (!a_rvalid && a_rdata == '0)); // R7
  AST_TDP_A_READ: assert property (@(posedge clk) disable iff (rst)
    (TDP && a_en && !a_we) |=> a_rvalid); // R8
  AST_B_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(b_en && !b_we) |=> $stable(b_rdata)); // R9
  AST_A_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(a_en && !a_we) |=> $stable(a_rdata)); // R9
endmodule

bind asym_dp_ram amem_checker #(
  .TDP(DP_MODE == amem_pkg::MODE_TRUE),
  .A_W(A_W),
  .B_W(B_W)
) u_chk (
  .clk(clk), .rst(rst), .a_en(a_en), .a_we(a_we), .b_en(b_en), .b_we(b_we),
  .a_rdata(a_rdata), .a_rvalid(a_rvalid), .b_rdata(b_rdata), .b_rvalid(b_rvalid)
);

// File: tb/asym_dp_ram_test.sv
module asym_dp_ram_test;
  localparam int LANE_W = 8, A_LANES = 4, B_LANES = 1, A_DEPTH = 256;
  localparam int NL = A_LANES * A_DEPTH;

  function automatic logic [NL*LANE_W-1:0] mk_init();
    logic [NL*LANE_W-1:0] v;
    for (int i = 0; i < NL; i++) v[i*LANE_W +: LANE_W] = LANE_W'((i * 37 + 11) % 256);
    return v;
  endfunction
  localparam logic [NL*LANE_W-1:0] INIT_P = mk_init();

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_en = 0, a_we = 0, b_en = 0, b_we = 0;
  logic [3:0]  a_be = '0;
  logic [0:0]  b_be = '0;
  logic [7:0]  a_addr = '0;
  logic [9:0]  b_addr = '0;
  logic [31:0] a_wdata = '0;
  logic [7:0]  b_wdata = '0;
  logic [31:0] ard_t, ard_s;
  logic [7:0]  brd_t, brd_s;
  logic arv_t, arv_s, brv_t, brv_s;

  always #2.5 clk = ~clk;

  asym_dp_ram #(.LANE_W(LANE_W), .A_LANES(A_LANES), .B_LANES(B_LANES), .A_DEPTH(A_DEPTH),
    .DP_MODE(amem_pkg::MODE_TRUE), .INIT(INIT_P)) uut (
    .clk(clk), .rst(rst), .a_en(a_en), .a_we(a_we), .a_be(a_be), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rdata(ard_t), .a_rvalid(arv_t), .b_en(b_en), .b_we(b_we),
    .b_be(b_be), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(brd_t), .b_rvalid(brv_t));

  asym_dp_ram #(.LANE_W(LANE_W), .A_LANES(A_LANES), .B_LANES(B_LANES), .A_DEPTH(A_DEPTH),
    .DP_MODE(amem_pkg::MODE_SIMPLE), .INIT(INIT_P)) uut_sdp (
    .clk(clk), .rst(rst), .a_en(a_en), .a_we(a_we), .a_be(a_be), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rdata(ard_s), .a_rvalid(arv_s), .b_en(b_en), .b_we(b_we),
    .b_be(b_be), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(brd_s), .b_rvalid(brv_s));

  int ref_t[NL];
  int ref_s[NL];
  logic [31:0] ea_t = '0, ea_s = '0;
  logic [7:0]  eb_t = '0, eb_s = '0;
  logic eav_t = 0, eav_s = 0, ebv_t = 0, ebv_s = 0;
  int checks = 0, failures = 0;
  bit done = 0;
  string phase = "R1";

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  task automatic tick();
    if (rst) begin
      for (int i = 0; i < NL; i++) begin
        ref_t[i] = int'(INIT_P[i*LANE_W +: LANE_W]);
        ref_s[i] = ref_t[i];
      end
      ea_t = '0; ea_s = '0; eb_t = '0; eb_s = '0;
      eav_t = 0; eav_s = 0; ebv_t = 0; ebv_s = 0;
    end else begin
      if (a_en && !a_we) begin
        for (int l = 0; l < 4; l++) ea_t[l*8 +: 8] = 8'(ref_t[int'(a_addr)*4 + l]);
        eav_t = 1;
      end else eav_t = 0;
      eav_s = 0;
      if (b_en && !b_we) begin
        eb_t = 8'(ref_t[int'(b_addr)]);
        eb_s = 8'(ref_s[int'(b_addr)]);
        ebv_t = 1; ebv_s = 1;
      end else begin
        ebv_t = 0; ebv_s = 0;
      end
      if (b_en && b_we && b_be[0]) ref_t[int'(b_addr)] = int'(b_wdata);
      if (a_en && a_we)
        for (int l = 0; l < 4; l++)
          if (a_be[l]) begin
            ref_t[int'(a_addr)*4 + l] = int'(a_wdata[l*8 +: 8]);
            ref_s[int'(a_addr)*4 + l] = int'(a_wdata[l*8 +: 8]);
          end
    end
    @(posedge clk);
    #1;
    chk("tdp a_rvalid", 32'(arv_t), 32'(eav_t));
    chk("tdp a_rdata",  ard_t, ea_t);
    chk("tdp b_rvalid", 32'(brv_t), 32'(ebv_t));
    chk("tdp b_rdata",  32'(brd_t), 32'(eb_t));
    chk("sdp a_rvalid", 32'(arv_s), 32'(eav_s));
    chk("sdp a_rdata",  ard_s, ea_s);
    chk("sdp b_rvalid", 32'(brv_s), 32'(ebv_s));
    chk("sdp b_rdata",  32'(brd_s), 32'(eb_s));
  endtask

  task automatic drv_a(logic en, logic we, logic [3:0] be, logic [7:0] ad, logic [31:0] d);
    a_en = en; a_we = we; a_be = be; a_addr = ad; a_wdata = d;
  endtask

  task automatic drv_b(logic en, logic we, logic be, logic [9:0] ad, logic [7:0] d);
    b_en = en; b_we = we; b_be = be; b_addr = ad; b_wdata = d;
  endtask

  task automatic idle();
    drv_a(0, 0, 4'h0, 8'h0, 32'h0);
    drv_b(0, 0, 1'b0, 10'h0, 8'h0);
  endtask

  initial begin
    int seed;
    #1;
    phase = "R1";
    rst = 1; idle(); tick(); tick();
    rst = 0; tick();

    phase = "R1 R2 R3 R8";
    for (int i = 0; i < 16; i++) begin
      drv_b(1, 0, 1'b0, 10'(i), 8'h0);
      drv_a(1, 0, 4'h0, 8'(i % 4), 32'h0);
      tick();
    end

    phase = "R9";
    idle(); tick(); tick();

    phase = "R4";
    drv_a(1, 1, 4'b0101, 8'd3, 32'hAABBCCDD); tick();
    idle();
    for (int i = 12; i < 16; i++) begin drv_b(1, 0, 1'b0, 10'(i), 8'h0); tick(); end
    drv_b(0, 0, 1'b0, 10'h0, 8'h0);
    drv_a(1, 0, 4'h0, 8'd3, 32'h0); tick();

    phase = "R5";
    drv_a(1, 1, 4'hF, 8'd5, 32'h11223344);
    drv_b(1, 0, 1'b0, 10'd21, 8'h0); tick();
    idle(); drv_b(1, 0, 1'b0, 10'd21, 8'h0); tick();
    drv_b(1, 1, 1'b1, 10'd22, 8'h9C);
    drv_a(1, 0, 4'h0, 8'd5, 32'h0); tick();
    idle(); drv_a(1, 0, 4'h0, 8'd5, 32'h0); tick();

    phase = "R10";
    drv_a(1, 1, 4'hF, 8'd10, 32'hCAFEF00D);
    drv_b(1, 0, 1'b0, 10'd80, 8'h0); tick();
    idle(); drv_b(1, 0, 1'b0, 10'd41, 8'h0); tick();

    phase = "R6";
    drv_a(1, 1, 4'hF, 8'd12, 32'h55667788);
    drv_b(1, 1, 1'b1, 10'd50, 8'hEE); tick();
    idle(); drv_b(1, 0, 1'b0, 10'd50, 8'h0); tick();

    phase = "R6 R7 R8";
    drv_a(1, 1, 4'b1011, 8'd12, 32'h01020304);
    drv_b(1, 1, 1'b1, 10'd50, 8'hEE); tick();
    idle(); drv_b(1, 0, 1'b0, 10'd50, 8'h0); tick();
    drv_b(1, 0, 1'b0, 10'd49, 8'h0); tick();

    phase = "R7 R8";
    idle(); drv_b(1, 1, 1'b1, 10'd200, 8'h5A); tick();
    idle(); drv_b(1, 1, 1'b0, 10'd201, 8'h77); tick();
    idle(); drv_a(1, 0, 4'h0, 8'd50, 32'h0); tick();
    idle(); drv_b(1, 0, 1'b0, 10'd200, 8'h0); tick();
    idle(); drv_b(1, 0, 1'b0, 10'd201, 8'h0); tick();

    phase = "R1";
    idle(); rst = 1; tick(); rst = 0; tick();
    drv_b(1, 0, 1'b0, 10'd50, 8'h0); drv_a(1, 0, 4'h0, 8'd3, 32'h0); tick();

    phase = "R2 R3 R4 R5 R6 R8 R9 R10";
    seed = 32'h1F2E3D4C;
    for (int n = 0; n < 600; n++) begin
      seed = seed * 1103515245 + 12345;
      drv_a(seed[16], seed[17], seed[21:18], {5'b0, seed[24:22]}, {seed[15:0], seed[31:16]});
      seed = seed * 1103515245 + 12345;
      drv_b(seed[16], seed[17], seed[18], {5'b0, seed[23:19]}, seed[31:24]);
      tick();
    end

    phase = "R9";
    idle(); tick(); tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog %s actual=hung expected=finished", phase);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule